// File: doc/BRIEF.md
# Byte Rotate and Shift Unit

A purely combinational datapath slice that takes one operand byte, the current carry flag and a 3-bit operation selector, and returns the rotated or shifted byte together with a full eight-bit flag byte. It covers the rotates, both circular and through the carry, and the arithmetic, logical and set-bit shifts in both directions. A CPU core places it beside its adder ALU and merges the flag byte into its flag register as it is.

Every operation moves exactly one bit out into the carry flag. The sign, zero, two copied result bits and even parity all come from the result byte, so a following conditional branch can test the outcome of any of the eight operations in the same way.

Top module: `byte_shifter`

## Requirements
- R1: The flag byte has the layout bit7 sign, bit6 zero, bit5 copy of result bit 5, bit4 half-carry, bit3 copy of result bit 3, bit2 parity, bit1 subtract, bit0 carry; half-carry (bit4) and subtract (bit1) are always 0.
- R2: Selector 0 rotates left circularly: result = {a[6:0], a[7]}, carry out = a[7].
- R3: Selector 1 rotates right circularly: result = {a[0], a[7:1]}, carry out = a[0].
- R4: Selector 2 rotates left through carry: result = {a[6:0], cin}, carry out = a[7].
- R5: Selector 3 rotates right through carry: result = {cin, a[7:1]}, carry out = a[0].
- R6: Selector 4 shifts left with zero fill: result = {a[6:0], 0}, carry out = a[7].
- R7: Selector 5 shifts right arithmetically, keeping bit 7: result = {a[7], a[7:1]}, carry out = a[0].
- R8: Selector 6 shifts left and sets bit 0: result = {a[6:0], 1}, carry out = a[7].
- R9: Selector 7 shifts right with zero fill: result = {0, a[7:1]}, carry out = a[0].
- R10: Flag bits 7, 5 and 3 equal result bits 7, 5 and 3 for every selector.
- R11: Flag bit 6 is 1 exactly when the result byte is zero.
- R12: Flag bit 2 is 1 exactly when the result byte holds an even number of one bits.
- R13: The incoming carry affects only selectors 2 and 3; for every other selector the outputs do not depend on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 8 | Operand byte |
| cin_i | input | 1 | Incoming carry flag |
| op_i | input | 3 | Operation selector, 0..7 |
| res_o | output | 8 | Rotated or shifted byte |
| flags_o | output | 8 | Complete flag byte |

## Verification
The block has no parameters, so the bench builds it as it stands and drives its whole input space: all eight selectors, all 256 operand values and both carry states. Expected results come from multiplying and dividing the operand by two in the bench and adding the inserted bit, with parity found by counting bits, so each shift, fill rule, carry out and flag is compared for every combination, including the zero and all-ones operands.

// File: rtl/byte_shifter.sv
module byte_shifter (
  input  logic [7:0] opnd_i,
  input  logic       cin_i,
  input  logic [2:0] op_i,
  output logic [7:0] res_o,
  output logic [7:0] flags_o
);

  localparam logic [2:0] OP_ROTL    = 3'd0;
  localparam logic [2:0] OP_ROTR    = 3'd1;
  localparam logic [2:0] OP_ROTL_C  = 3'd2;
  localparam logic [2:0] OP_ROTR_C  = 3'd3;
  localparam logic [2:0] OP_SHL     = 3'd4;
  localparam logic [2:0] OP_SHR_A   = 3'd5;
  localparam logic [2:0] OP_SHL_ONE = 3'd6;
  localparam logic [2:0] OP_SHR_L   = 3'd7;

  always_comb begin
    logic [7:0] r;
    logic       c;
    logic       left;
    logic       fill;
    left = ~op_i[0];
    case (op_i)
      OP_ROTL:    begin r = {opnd_i[6:0], opnd_i[7]}; c = opnd_i[7]; end
      OP_ROTR:    begin r = {opnd_i[0], opnd_i[7:1]}; c = opnd_i[0]; end
      OP_ROTL_C:  begin r = {opnd_i[6:0], cin_i};     c = opnd_i[7]; end
      OP_ROTR_C:  begin r = {cin_i, opnd_i[7:1]};     c = opnd_i[0]; end
      OP_SHL:     begin r = {opnd_i[6:0], 1'b0};      c = opnd_i[7]; end
      OP_SHR_A:   begin r = {opnd_i[7], opnd_i[7:1]}; c = opnd_i[0]; end
      OP_SHL_ONE: begin r = {opnd_i[6:0], 1'b1};      c = opnd_i[7]; end
      default:    begin r = {1'b0, opnd_i[7:1]};      c = opnd_i[0]; end
    endcase
    res_o   = r;
    flags_o = {r[7], (r == 8'h00), r[5], 1'b0, r[3], ~^r, 1'b0, c};

    fill = left ? res_o[0] : res_o[7];

    // R2..R9: the carry out is the bit shifted off the end
    p_carry_out_r2: assert (flags_o[0] == (left ? opnd_i[7] : opnd_i[0]));
    // R2..R9: surviving bits move by one position
    p_body_moves_r6: assert (left ? (res_o[7:1] == opnd_i[6:0]) : (res_o[6:0] == opnd_i[7:1]));
    // R2, R3: circular rotate puts the lost bit back in
    p_circ_fill_r3: assert (op_i[2:1] != 2'b00 || fill == flags_o[0]);
    // R4, R5, R13: only through-carry rotates insert the incoming carry
    p_thru_fill_r13: assert (op_i[2:1] != 2'b01 || fill == cin_i);
    // R7: arithmetic right shift keeps the sign
    p_sign_kept_r7: assert (op_i != OP_SHR_A || res_o[7] == opnd_i[7]);
    // R8: set-bit left shift always ends in one
    p_low_set_r8: assert (op_i != OP_SHL_ONE || res_o[0]);
    // R11: zero flag agrees with the result
    p_zero_flag_r11: assert (flags_o[6] == (res_o == 8'h00));
  end

endmodule

// File: tb/byte_shifter_test.sv
module byte_shifter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [7:0] opnd_i;
  logic       cin_i;
  logic [2:0] op_i;
  logic [7:0] res_o;
  logic [7:0] flags_o;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  byte_shifter uut (
    .opnd_i (opnd_i),
    .cin_i  (cin_i),
    .op_i   (op_i),
    .res_o  (res_o),
    .flags_o(flags_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s op=%0d a=%02h c=%0d got=%0h exp=%0h", req, op_i, opnd_i, cin_i, got, exp);
    end
  endtask

  function automatic string op_req(input int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 256; a++) begin
        int other_res;
        int other_flags;
        for (int c = 0; c < 2; c++) begin
          int exp_r;
          int exp_c;
          int ones;
          @(negedge clk);
          opnd_i = a[7:0];
          cin_i  = c[0];
          op_i   = op[2:0];
          #1;
          if (op % 2 == 0) begin
            exp_r = (a * 2) % 256;
            exp_c = a / 128;
            case (op)
              0: exp_r = exp_r + a / 128;
              2: exp_r = exp_r + c;
              6: exp_r = exp_r + 1;
              default: ;
            endcase
          end else begin
            exp_r = a / 2;
            exp_c = a % 2;
            case (op)
              1: exp_r = exp_r + 128 * (a % 2);
              3: exp_r = exp_r + 128 * c;
              5: exp_r = exp_r + 128 * (a / 128);
              default: ;
            endcase
          end
          ones = 0;
          for (int b = 0; b < 8; b++) ones += (exp_r >> b) % 2;
          check(op_req(op), res_o, exp_r);
          check(op_req(op), flags_o[0], exp_c);
          check("R1", {flags_o[4], flags_o[1]}, 0);
          check("R10", {flags_o[7], flags_o[5], flags_o[3]},
                4 * (exp_r / 128) + 2 * ((exp_r / 32) % 2) + (exp_r / 8) % 2);
          check("R11", flags_o[6], (exp_r == 0) ? 1 : 0);
          check("R12", flags_o[2], (ones % 2 == 0) ? 1 : 0);
          if (c == 0) begin
            other_res   = res_o;
            other_flags = flags_o;
          end else if (op != 2 && op != 3) begin
            check("R13", {res_o, flags_o}, {other_res[7:0], other_flags[7:0]});
          end
        end
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule